// File: doc/BRIEF.md
# Status Poll Engine for a Serial Configuration Port

This block sits on the master side of an SPI link to a slave configuration port. When the caller requests a poll, the engine repeatedly reads the slave's one-byte status register. It compares each result against a caller-supplied mask, and it stops when the slave is in the wanted state, when the slave reports a protocol fault, or when a fixed time limit has passed. The caller sees a one-cycle completion pulse, two flags that qualify it, and the last status byte that was sampled.

The slave presents its status on MISO during the byte in which a read-status opcode of 0x00 is being shifted in. The first reading after a select is not reliable. For that reason, every sample is taken as two single-byte frames with the select released between them, and only the second byte is used. Samples follow one another with no idle delay. The time limit is a cycle counter derived from the system clock frequency and a limit in microseconds.

The link runs in mode 0 (SCLK idles low, data is captured on the rising edge), most significant bit first. A parameter sets the number of system clocks per SCLK half period.

Top module: `statpoll_engine`

## Requirements
- R1: After reset, csN is high, sclk is low and pollDone is low.
- R2: Each status sample consists of exactly two frames. Each frame holds csN low for exactly 8 rising SCLK edges, and MOSI stays 0 throughout, which shifts out the opcode 0x00.
- R3: The byte received in the first frame of a sample is discarded. Only the second frame's byte is evaluated and reported.
- R4: Received bits are captured on rising SCLK edges, most significant bit first. SCLK is low whenever csN is high.
- R5: When a sampled byte has bit 2 (violation) or bit 3 (fault) set, the poll ends with pollErr=1 and pollTimeout=0, and statusOut holds that byte. This check takes priority over the success check.
- R6: A sampled byte s with no fault bits ends the poll successfully (pollErr=0, pollTimeout=0, statusOut=s) when (s AND (mask OR 0x01)) equals mask. Bit 0 means busy and bit 1 means ready. A mask of 0x00 waits for "not busy", and a mask of 0x02 waits for "ready and not busy".
- R7: A sample that neither fails nor succeeds is followed immediately by the next sample.
- R8: The timer starts when the request is accepted. A sample that completes after the limit has elapsed and is neither a fault nor a success ends the poll with pollTimeout=1 and pollErr=0. Such a poll never ends before the limit.
- R9: pollDone is a single-cycle pulse. pollErr and pollTimeout are valid while it is high, and they hold their values until the next completion.
- R10: Between two frames, csN stays high for at least two SCLK half periods.
- R11: A pollReq raised while a poll is in progress has no effect. It does not change the latched mask and it does not restart the sampling.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low asynchronous reset |
| pollReq | input | 1 | Start a poll; accepted only while idle |
| pollMask | input | 8 | Mask that the status must match, latched on acceptance |
| pollDone | output | 1 | One-cycle completion pulse |
| pollErr | output | 1 | Poll ended on a protocol fault bit |
| pollTimeout | output | 1 | Poll ended on the time limit |
| statusOut | output | 8 | Last evaluated status byte |
| sclk | output | 1 | SPI serial clock, mode 0 |
| csN | output | 1 | SPI chip select, active low |
| mosi | output | 1 | SPI master-out data |
| miso | input | 1 | SPI master-in data |

## Verification
The bench builds the engine with a 1 MHz nominal clock and a 2000 µs limit, which gives a 2000-cycle timeout. It also uses an SCLK half period of two clocks, so one sample takes about 74 cycles. With these values a slave that stays busy forever reaches the timeout after roughly 27 samples, while every scripted or random poll of up to seven samples finishes well inside the limit. The bench's slave model returns a byte with both fault bits set in every discarded frame. Any use of the wrong frame therefore shows up as a spurious error.

// File: rtl/statpoll_pkg.sv
package statpoll_pkg;

  typedef enum logic [1:0] {
    S_IDLE,
    S_FIRST,
    S_SECOND
  } pollState_t;

  typedef enum logic [1:0] {
    X_IDLE,
    X_LOW,
    X_HIGH,
    X_GAP
  } xferState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic loadMask;
    logic clearTimer;
    logic startXfer;
    logic capture;
    logic running;
  } stb_t;

  localparam logic [7:0] BUSY_BIT = 8'h01;

endpackage

// File: rtl/statpoll_dp.sv
module statpoll_dp
  import statpoll_pkg::*;
#(
  parameter int unsigned SCLK_HALF = 4,
  parameter int unsigned TMO_CYCLES = 1000
) (
  input  logic       clk,
  input  logic       rstN,
  input  stb_t       stb,
  input  logic [7:0] pollMask,
  input  logic       miso,
  output logic       sclk,
  output logic       csN,
  output logic       mosi,
  output logic       xferDone,
  output logic [7:0] rxByte,
  output logic [7:0] maskQ,
  output logic [7:0] statusQ,
  output logic       timedOut
);

  localparam int unsigned GAP = 2 * SCLK_HALF;
  localparam int unsigned DW  = $clog2(GAP + 1);
  localparam int unsigned TW  = $clog2(TMO_CYCLES + 1);
  localparam logic [DW-1:0] HALF_END = DW'(SCLK_HALF - 1);
  localparam logic [DW-1:0] GAP_END  = DW'(GAP - 1);
  localparam logic [TW-1:0] TMO_LIM  = TW'(TMO_CYCLES);

  xferState_t    xState;
  logic [DW-1:0] divCnt;
  logic [2:0]    bitCnt;
  logic [7:0]    rxShift;
  logic [TW-1:0] timer;

  assign mosi     = 1'b0;  // read-status opcode is all zeros
  assign rxByte   = rxShift;
  assign timedOut = (timer >= TMO_LIM);

  // serial shifter
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      xState   <= X_IDLE;
      divCnt   <= '0;
      bitCnt   <= '0;
      rxShift  <= '0;
      sclk     <= 1'b0;
      csN      <= 1'b1;
      xferDone <= 1'b0;
    end else begin
      xferDone <= 1'b0;
      case (xState)
        X_IDLE: if (stb.startXfer) begin
          csN    <= 1'b0;
          sclk   <= 1'b0;
          divCnt <= '0;
          bitCnt <= '0;
          xState <= X_LOW;
        end
        X_LOW: if (divCnt == HALF_END) begin
          sclk    <= 1'b1;
          rxShift <= {rxShift[6:0], miso};
          divCnt  <= '0;
          xState  <= X_HIGH;
        end else divCnt <= divCnt + 1'b1;
        X_HIGH: if (divCnt == HALF_END) begin
          sclk   <= 1'b0;
          divCnt <= '0;
          if (bitCnt == 3'd7) begin
            csN    <= 1'b1;
            xState <= X_GAP;
          end else begin
            bitCnt <= bitCnt + 1'b1;
            xState <= X_LOW;
          end
        end else divCnt <= divCnt + 1'b1;
        default: if (divCnt == GAP_END) begin
          divCnt   <= '0;
          xferDone <= 1'b1;
          xState   <= X_IDLE;
        end else divCnt <= divCnt + 1'b1;
      endcase
    end
  end

  // mask, status and timeout registers
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      maskQ   <= '0;
      statusQ <= '0;
      timer   <= '0;
    end else begin
      if (stb.loadMask) maskQ <= pollMask;
      if (stb.capture)  statusQ <= rxShift;
      if (stb.clearTimer) timer <= '0;
      else if (stb.running && !timedOut) timer <= timer + 1'b1;
    end
  end

  a_r4_sclk_low_idle: assert property (@(posedge clk) disable iff (!rstN)
    csN |-> !sclk);
  a_r10_cs_gap: assert property (@(posedge clk) disable iff (!rstN)
    $rose(csN) |=> csN);
  a_r8_timer_bound: assert property (@(posedge clk) disable iff (!rstN)
    timer <= TMO_LIM);

endmodule

// File: rtl/statpoll_ctrl.sv
module statpoll_ctrl
  import statpoll_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       pollReq,
  input  logic       xferDone,
  input  logic [7:0] rxByte,
  input  logic [7:0] maskQ,
  input  logic       timedOut,
  output stb_t       stb,
  output logic       pollDone,
  output logic       pollErr,
  output logic       pollTimeout
);

  pollState_t state, stateNext;
  logic finish, errNext, tmoNext, isFault, isMatch;

  assign isFault = |rxByte[3:2];
  assign isMatch = ((rxByte & (maskQ | BUSY_BIT)) == maskQ);

  always_comb begin
    stb       = '0;
    stateNext = state;
    finish    = 1'b0;
    errNext   = 1'b0;
    tmoNext   = 1'b0;
    stb.running = (state != S_IDLE);
    case (state)
      S_IDLE: if (pollReq) begin
        stb.loadMask   = 1'b1;
        stb.clearTimer = 1'b1;
        stb.startXfer  = 1'b1;
        stateNext      = S_FIRST;
      end
      S_FIRST: if (xferDone) begin
        stb.startXfer = 1'b1;
        stateNext     = S_SECOND;
      end
      default: if (xferDone) begin
        stb.capture = 1'b1;
        if (isFault) begin
          finish = 1'b1; errNext = 1'b1; stateNext = S_IDLE;
        end else if (isMatch) begin
          finish = 1'b1; stateNext = S_IDLE;
        end else if (timedOut) begin
          finish = 1'b1; tmoNext = 1'b1; stateNext = S_IDLE;
        end else begin
          stb.startXfer = 1'b1;
          stateNext     = S_FIRST;
        end
      end
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state       <= S_IDLE;
      pollDone    <= 1'b0;
      pollErr     <= 1'b0;
      pollTimeout <= 1'b0;
    end else begin
      state    <= stateNext;
      pollDone <= finish;
      if (finish) begin
        pollErr     <= errNext;
        pollTimeout <= tmoNext;
      end
    end
  end

  a_r9_done_pulse: assert property (@(posedge clk) disable iff (!rstN)
    pollDone |=> !pollDone);
  a_r9_flags_exclusive: assert property (@(posedge clk) disable iff (!rstN)
    pollDone |-> !(pollErr && pollTimeout));
  a_r3_first_discarded: assert property (@(posedge clk) disable iff (!rstN)
    (state == S_FIRST && xferDone) |=> !pollDone);
  a_r11_req_ignored: assert property (@(posedge clk) disable iff (!rstN)
    (state != S_IDLE && pollReq) |-> !stb.loadMask);

endmodule

// File: rtl/statpoll_engine.sv
module statpoll_engine
  import statpoll_pkg::*;
#(
  parameter int unsigned CLK_HZ     = 100_000_000,
  parameter int unsigned LIMIT_US   = 2_000_000,
  parameter int unsigned SCLK_HALF  = 4
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       pollReq,
  input  logic [7:0] pollMask,
  output logic       pollDone,
  output logic       pollErr,
  output logic       pollTimeout,
  output logic [7:0] statusOut,
  output logic       sclk,
  output logic       csN,
  output logic       mosi,
  input  logic       miso
);

  localparam int unsigned TMO_CYCLES = (CLK_HZ / 1_000_000) * LIMIT_US;

  stb_t       stb;
  logic       xferDone, timedOut;
  logic [7:0] rxByte, maskQ;

  statpoll_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .pollReq(pollReq), .xferDone(xferDone),
    .rxByte(rxByte), .maskQ(maskQ), .timedOut(timedOut), .stb(stb),
    .pollDone(pollDone), .pollErr(pollErr), .pollTimeout(pollTimeout)
  );

  statpoll_dp #(.SCLK_HALF(SCLK_HALF), .TMO_CYCLES(TMO_CYCLES)) u_dp (
    .clk(clk), .rstN(rstN), .stb(stb), .pollMask(pollMask), .miso(miso),
    .sclk(sclk), .csN(csN), .mosi(mosi), .xferDone(xferDone),
    .rxByte(rxByte), .maskQ(maskQ), .statusQ(statusOut), .timedOut(timedOut)
  );

  a_r5_fault_reported: assert property (@(posedge clk) disable iff (!rstN)
    (pollDone && pollErr) |-> (statusOut[3:2] != 2'b00));
  a_r6_match_reported: assert property (@(posedge clk) disable iff (!rstN)
    (pollDone && !pollErr && !pollTimeout) |->
      ((statusOut & (maskQ | BUSY_BIT)) == maskQ));
  a_r8_timeout_late: assert property (@(posedge clk) disable iff (!rstN)
    (pollDone && pollTimeout) |-> timedOut);

endmodule

// File: tb/statpoll_engine_bench.sv
module statpoll_engine_bench;

  localparam int HALF = 2;
  localparam int TMO  = 2000;
  localparam logic [7:0] JUNK = 8'h0E;

  logic clk = 0, rstN = 0, pollReq = 0, miso = 0;
  logic [7:0] pollMask = 0;
  logic pollDone, pollErr, pollTimeout, sclk, csN, mosi;
  logic [7:0] statusOut;

  statpoll_engine #(.CLK_HZ(1_000_000), .LIMIT_US(TMO), .SCLK_HALF(HALF))
  u_statpoll_engine (
    .clk(clk), .rstN(rstN), .pollReq(pollReq), .pollMask(pollMask),
    .pollDone(pollDone), .pollErr(pollErr), .pollTimeout(pollTimeout),
    .statusOut(statusOut), .sclk(sclk), .csN(csN), .mosi(mosi), .miso(miso)
  );

  always #5 clk = ~clk;

  int nChk = 0, nBad = 0;
  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  // slave model and link monitor
  logic [7:0] script [0:15];
  int scriptLen = 0;
  logic [7:0] fallback = 8'h00;
  int frameIdx = 0, sampleIdx = 0;
  logic [7:0] txByte = 0;
  int bitPos = 7;
  int edges = 0, badFrames = 0, mosiBad = 0, minGap = 1000, csRiseCyc = -1;
  int doneWidthBad = 0;

  always @(negedge csN) begin
    if (frameIdx % 2 == 0) txByte = JUNK;
    else begin
      txByte = (sampleIdx < scriptLen) ? script[sampleIdx] : fallback;
      sampleIdx++;
    end
    frameIdx++;
    bitPos = 7;
    miso = txByte[7];
    edges = 0;
    if (csRiseCyc >= 0 && (cyc - csRiseCyc) < minGap) minGap = cyc - csRiseCyc;
  end
  always @(negedge sclk) if (!csN && bitPos > 0) begin
    bitPos--;
    miso = txByte[bitPos];
  end
  always @(posedge sclk) begin
    edges++;
    if (mosi !== 1'b0) mosiBad++;
  end
  always @(posedge csN) begin
    if (edges != 8) badFrames++;
    csRiseCyc = cyc;
  end
  logic prevDone = 0;
  always @(negedge clk) begin
    if (prevDone && pollDone) doneWidthBad++;
    prevDone = pollDone;
  end

  task automatic check(input string req, input int act, input int exp);
    nChk++;
    if (act != exp) begin
      nBad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // expected outcome: 0 ok, 1 err, 2 timeout; returns samples used
  function automatic int predict(input logic [7:0] m, input int len,
                                 output int kind, output logic [7:0] st);
    for (int i = 0; i < 64; i++) begin
      logic [7:0] s;
      s = (i < len) ? script[i] : fallback;
      if (s[3:2] != 0) begin kind = 1; st = s; return i + 1; end
      if ((s & (m | 8'h01)) == m) begin kind = 0; st = s; return i + 1; end
    end
    kind = 2; st = fallback;
    return 0;
  endfunction

  task automatic runPoll(input string tag, input logic [7:0] m, input int len,
                         input bit midReq);
    int kind, expSamples, t0, el;
    logic [7:0] expSt;
    bit seen;
    expSamples = predict(m, len, kind, expSt);
    scriptLen = len; frameIdx = 0; sampleIdx = 0;
    edges = 0; badFrames = 0; mosiBad = 0; minGap = 1000; csRiseCyc = -1;
    doneWidthBad = 0;
    @(negedge clk);
    pollMask = m; pollReq = 1;
    @(negedge clk);
    pollReq = 0; t0 = cyc;
    seen = 0;
    for (int w = 0; w < TMO + 400; w++) begin
      if (midReq && w == 10) begin pollReq = 1; pollMask = 8'h00; end
      if (midReq && w == 11) pollReq = 0;
      if (pollDone) begin seen = 1; break; end
      @(negedge clk);
    end
    el = cyc - t0;
    check({tag, " R9 done seen"}, seen, 1);
    check({tag, " R5 err flag"}, pollErr, kind == 1);
    check({tag, " R8 timeout flag"}, pollTimeout, kind == 2);
    if (kind != 2) begin
      check({tag, " R6/R3 status"}, statusOut, expSt);
      check({tag, " R7 samples"}, frameIdx / 2, expSamples);
    end else begin
      check({tag, " R8 not early"}, el >= TMO, 1);
      check({tag, " R8 not late"}, el <= TMO + 2 * (18 * HALF + 2) + 4, 1);
    end
    check({tag, " R2 frame pairs"}, frameIdx % 2, 0);
    check({tag, " R2/R4 edges per frame"}, badFrames, 0);
    check({tag, " R2 mosi zero"}, mosiBad, 0);
    if (frameIdx > 1) check({tag, " R10 gap"}, minGap >= 2 * HALF, 1);
    @(negedge clk);
    check({tag, " R9 pulse width"}, doneWidthBad + pollDone, 0);
    check({tag, " R9 flags held"}, pollErr, kind == 1);
  endtask

  initial begin
    void'($urandom(32'd4711));
    repeat (3) @(negedge clk);
    check("R1 csN idle", csN, 1);
    check("R1 sclk idle", sclk, 0);
    check("R1 done idle", pollDone, 0);
    rstN = 1;
    repeat (2) @(negedge clk);

    // R6 not busy, mask 0
    script[0] = 8'h01; script[1] = 8'h03; script[2] = 8'h02;
    fallback = 8'h00;
    runPoll("notbusy", 8'h00, 3, 0);
    // R6 ready and not busy
    script[0] = 8'h00; script[1] = 8'h03; script[2] = 8'h02;
    fallback = 8'h02;
    runPoll("ready", 8'h02, 3, 0);
    // R5 violation bit
    script[0] = 8'h01; script[1] = 8'h05;
    runPoll("viol", 8'h02, 2, 0);
    // R5 fault bit beats match
    script[0] = 8'h08;
    runPoll("fault", 8'h00, 1, 0);
    // R11 mid-poll request ignored
    script[0] = 8'h03; script[1] = 8'h00; script[2] = 8'h02;
    runPoll("midreq", 8'h02, 3, 1);
    // R8 slave stays busy
    fallback = 8'h01;
    runPoll("timeout", 8'h00, 0, 0);

    // random polls
    for (int n = 0; n < 20; n++) begin
      logic [7:0] m;
      int len;
      m = ($urandom % 2) ? 8'h02 : 8'h00;
      len = $urandom % 7;
      for (int i = 0; i < len; i++) begin
        script[i] = 8'($urandom % 4);
        if ($urandom % 8 == 0) script[i][2 + ($urandom % 2)] = 1'b1;
      end
      fallback = m;
      runPoll($sformatf("rand%0d", n), m, len, 0);
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChk, nBad);
    $finish;
  end

  initial begin
    #(10 * 150000);
    nChk++; nBad++;
    $display("FAIL watchdog R9 actual=hung expected=finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChk, nBad);
    $finish;
  end

endmodule